// File: doc/BRIEF.md
# Split Page-Size Translation Lookaside Buffer

This block translates a virtual address into a physical address with one lookup per clock cycle. Its mappings are kept in two independent fully associative sections. One holds only 4 KiB page mappings and the other holds only large page mappings. The large pages are either 2 MiB or 4 MiB, chosen for the whole section by a static mode input. Both sections are searched at the same time, and a hit in either one supplies the translation. Each section compares a fixed tag width, so neither needs a per-entry size mask.

New mappings arrive on a fill port. A flag on that port says which section the fill goes to. A fill takes the lowest-numbered empty entry of its section. When the section is full, it takes the entry pointed to by a round-robin pointer. A flush input invalidates every mapping in both sections. Page walking, permission checks and address-space tags are left to the surrounding logic.

Top module: `split_tlb`

## Requirements
- R1: After the synchronous active-high reset every entry is invalid. `lk_hit` reads 0 and every lookup misses until a fill is made.
- R2: A lookup presented with `lk_valid`=1 at a rising edge drives `lk_hit`, `lk_large` and `lk_pa` from registers updated at that edge. A cycle with `lk_valid`=0 gives `lk_hit`=0 and `lk_large`=0.
- R3: A small-section hit gives `lk_large`=0 and `lk_pa` = {stored frame bits [PA_W-1:12], `lk_va`[11:0]}.
- R4: With `large_mode`=0 (2 MiB), a large-section entry matches on `lk_va`[VA_W-1:21]. A hit gives `lk_large`=1 and `lk_pa` = {stored frame bits [PA_W-1:21], `lk_va`[20:0]}.
- R5: With `large_mode`=1 (4 MiB), bit 21 takes no part in large-section matching. A hit gives `lk_pa` = {stored frame bits [PA_W-1:22], `lk_va`[21:0]}.
- R6: A fill with `fill_large`=0 stores `fill_va`[VA_W-1:12] and `fill_pa`[PA_W-1:12] in the small section only. A fill with `fill_large`=1 stores `fill_va`[VA_W-1:21] and `fill_pa`[PA_W-1:21] in the large section only. A small mapping never answers for another 4 KiB page.
- R7: A fill written at a rising edge is seen by lookups sampled at later edges. A lookup sampled at the same edge as the fill sees the contents from before the fill.
- R8: A fill goes to the lowest-indexed invalid entry of its section. If the section is full, it replaces the entry at the section's round-robin pointer. The pointer starts at 0 after reset or flush and advances by one, wrapping, on each such replacement.
- R9: If both sections match the same lookup, the large-section translation is returned with `lk_large`=1.
- R10: `flush` at a rising edge invalidates all entries in both sections. A fill at the same edge is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| large_mode | input | 1 | Static large page size: 0 = 2 MiB, 1 = 4 MiB |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_hit | output | 1 | Registered: translation found |
| lk_large | output | 1 | Registered: translation came from the large section |
| lk_pa | output | PA_W | Registered physical address |
| fill_en | input | 1 | Write a mapping |
| fill_large | input | 1 | 1 = large section, 0 = small section |
| fill_va | input | VA_W | Virtual address of the page being mapped |
| fill_pa | input | PA_W | Physical address of the page frame |
| flush | input | 1 | Invalidate all mappings |

## Verification
A lookup result is due one edge after the lookup is sampled. A fill or flush changes what a lookup sees from the next sampled edge on. The bench drives every input at the falling edge and holds it through exactly one rising edge. It reads the outputs at the following falling edge, which is the first point where that rising edge's registered result is visible. The same-edge cases (fill alongside a lookup, flush alongside a fill) are driven together in one cycle, and their effect is read in the cycles that follow.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int SMALL_OFS = 12;
  localparam int LARGE_OFS = 21;
  typedef enum logic {LG_2M = 1'b0, LG_4M = 1'b1} lg_mode_e;
endpackage

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               alloc,
  output logic [IW-1:0]      idx
);
  logic [IW-1:0] ptr;
  logic [IW-1:0] free_idx;
  logic          any_free;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  assign idx = any_free ? free_idx : ptr;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr <= '0;
    end else if (alloc && !any_free) begin
      if (ptr == IW'(ENTRIES - 1)) ptr <= '0;
      else                         ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/tlb_section.sv
module tlb_section #(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int FRM_W   = 20,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [FRM_W-1:0] wr_frame,
  input  logic [TAG_W-1:0] lk_tag,
  input  logic [TAG_W-1:0] tag_mask,
  output logic             hit,
  output logic [FRM_W-1:0] hit_frame
);
  logic [ENTRIES-1:0] valid;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [FRM_W-1:0]   frm_mem [ENTRIES];
  logic [ENTRIES-1:0] match;
  logic [IW-1:0]      wr_idx;
  logic               do_wr;

  assign do_wr = wr_en && !flush;

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .valid_vec(valid),
    .alloc    (do_wr),
    .idx      (wr_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || flush) valid <= '0;
    else if (do_wr)   valid[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      tag_mem[wr_idx] <= wr_tag;
      frm_mem[wr_idx] <= wr_frame;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (((tag_mem[g] ^ lk_tag) & tag_mask) == '0);
  end

  always_comb begin
    hit_frame = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_frame = frm_mem[i];
    end
  end

  assign hit = |match;
endmodule

// File: rtl/split_tlb.sv
module split_tlb #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int SMALL_ENT = 8,
  parameter int LARGE_ENT = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            large_mode,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_va,
  output logic            lk_hit,
  output logic            lk_large,
  output logic [PA_W-1:0] lk_pa,
  input  logic            fill_en,
  input  logic            fill_large,
  input  logic [VA_W-1:0] fill_va,
  input  logic [PA_W-1:0] fill_pa,
  input  logic            flush
);
  import tlb_pkg::*;

  localparam int ST_W = VA_W - SMALL_OFS;
  localparam int SF_W = PA_W - SMALL_OFS;
  localparam int LT_W = VA_W - LARGE_OFS;
  localparam int LF_W = PA_W - LARGE_OFS;

  lg_mode_e        mode;
  logic            hit_s, hit_l;
  logic [SF_W-1:0] frm_s;
  logic [LF_W-1:0] frm_l;
  logic [LT_W-1:0] lmask;
  logic [PA_W-1:0] pa_s, pa_l;
  logic            unused_fill_bits;

  assign mode  = lg_mode_e'(large_mode);
  assign lmask = {{(LT_W-1){1'b1}}, (mode == LG_2M)};
  assign unused_fill_bits = ^{fill_va[SMALL_OFS-1:0], fill_pa[LARGE_OFS-1:0]};

  tlb_section #(.ENTRIES(SMALL_ENT), .TAG_W(ST_W), .FRM_W(SF_W)) u_small (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wr_en    (fill_en && !fill_large),
    .wr_tag   (fill_va[VA_W-1:SMALL_OFS]),
    .wr_frame (fill_pa[PA_W-1:SMALL_OFS]),
    .lk_tag   (lk_va[VA_W-1:SMALL_OFS]),
    .tag_mask ({ST_W{1'b1}}),
    .hit      (hit_s),
    .hit_frame(frm_s)
  );

  tlb_section #(.ENTRIES(LARGE_ENT), .TAG_W(LT_W), .FRM_W(LF_W)) u_large (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .wr_en    (fill_en && fill_large),
    .wr_tag   (fill_va[VA_W-1:LARGE_OFS]),
    .wr_frame (fill_pa[PA_W-1:LARGE_OFS]),
    .lk_tag   (lk_va[VA_W-1:LARGE_OFS]),
    .tag_mask (lmask),
    .hit      (hit_l),
    .hit_frame(frm_l)
  );

  assign pa_s = {frm_s, lk_va[SMALL_OFS-1:0]};

  always_comb begin
    if (mode == LG_4M) pa_l = {frm_l[LF_W-1:1], lk_va[LARGE_OFS:0]};
    else               pa_l = {frm_l, lk_va[LARGE_OFS-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit   <= 1'b0;
      lk_large <= 1'b0;
      lk_pa    <= '0;
    end else begin
      lk_hit   <= lk_valid && (hit_s || hit_l);
      lk_large <= lk_valid && hit_l;
      lk_pa    <= hit_l ? pa_l : pa_s;
    end
  end
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            large_mode,
  input logic            lk_valid,
  input logic [VA_W-1:0] lk_va,
  input logic            lk_hit,
  input logic            lk_large,
  input logic [PA_W-1:0] lk_pa,
  input logic            flush,
  input logic            hit_s,
  input logic            hit_l
);
  logic seen_clk;
  always_ff @(posedge clk) begin
    if (rst) seen_clk <= 1'b0;
    else     seen_clk <= 1'b1;
  end

  p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    !$past(lk_valid) |-> (!lk_hit && !lk_large));

  p_large_implies_hit_r9: assert property (@(posedge clk) disable iff (rst)
    lk_large |-> lk_hit);

  p_small_offset_r3: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    (lk_hit && !lk_large) |-> (lk_pa[11:0] == $past(lk_va[11:0])));

  p_large_offset_2m_r4: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    (lk_large && !$past(large_mode)) |-> (lk_pa[20:0] == $past(lk_va[20:0])));

  p_large_offset_4m_r5: assert property (@(posedge clk) disable iff (rst || !seen_clk)
    (lk_large && $past(large_mode)) |-> (lk_pa[21:0] == $past(lk_va[21:0])));

  p_double_hit_large_r9: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && hit_s && hit_l) |=> lk_large);

  p_flush_clears_r10: assert property (@(posedge clk) disable iff (rst)
    flush |=> ##1 !lk_hit);
endmodule

bind split_tlb tlb_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .large_mode(large_mode),
  .lk_valid  (lk_valid),
  .lk_va     (lk_va),
  .lk_hit    (lk_hit),
  .lk_large  (lk_large),
  .lk_pa     (lk_pa),
  .flush     (flush),
  .hit_s     (hit_s),
  .hit_l     (hit_l)
);

// File: tb/sim_split_tlb.sv
module sim_split_tlb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        large_mode = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_hit, lk_large;
  logic [31:0] lk_pa;
  logic        fill_en = 1'b0;
  logic        fill_large = 1'b0;
  logic [31:0] fill_va = '0;
  logic [31:0] fill_pa = '0;
  logic        flush = 1'b0;

  int vectors = 0;
  int errors  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  split_tlb u0 (
    .clk(clk), .rst(rst), .large_mode(large_mode),
    .lk_valid(lk_valid), .lk_va(lk_va), .lk_hit(lk_hit),
    .lk_large(lk_large), .lk_pa(lk_pa),
    .fill_en(fill_en), .fill_large(fill_large),
    .fill_va(fill_va), .fill_pa(fill_pa), .flush(flush)
  );

  task automatic check(string req, logic hit, logic lg, logic [31:0] pa,
                       logic e_hit, logic e_lg, logic [31:0] e_pa);
    vectors++;
    if (hit !== e_hit || (e_hit && (lg !== e_lg || pa !== e_pa))) begin
      errors++;
      $display("FAIL %s: hit=%0b large=%0b pa=%h expected hit=%0b large=%0b pa=%h",
               req, hit, lg, pa, e_hit, e_lg, e_pa);
    end
  endtask

  task automatic do_fill(logic lg, logic [31:0] va, logic [31:0] pa);
    @(negedge clk);
    fill_en = 1'b1; fill_large = lg; fill_va = va; fill_pa = pa;
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic look(string req, logic [31:0] va,
                      logic e_hit, logic e_lg, logic [31:0] e_pa);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va;
    @(negedge clk);
    lk_valid = 1'b0;
    check(req, lk_hit, lk_large, lk_pa, e_hit, e_lg, e_pa);
  endtask

  task automatic t_reset();
    check("R1 out after reset", lk_hit, lk_large, lk_pa, 1'b0, 1'b0, '0);
    look("R1 lookup after reset", 32'h1234_5000, 1'b0, 1'b0, '0);
  endtask

  task automatic t_small();
    do_fill(1'b0, 32'h1234_5000, 32'h0ABC_D000);
    look("R3 small hit", 32'h1234_5678, 1'b1, 1'b0, 32'h0ABC_D678);
    look("R6 neighbour page miss", 32'h1234_6678, 1'b0, 1'b0, '0);
    do_fill(1'b0, 32'hFFFF_F000, 32'h0000_1000);
    look("R3 second small entry", 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0000_1FFF);
  endtask

  task automatic t_idle_and_order();
    @(negedge clk);
    lk_valid = 1'b0; lk_va = 32'h1234_5678;
    @(negedge clk);
    check("R2 no lookup no hit", lk_hit, lk_large, lk_pa, 1'b0, 1'b0, '0);
    @(negedge clk);
    fill_en = 1'b1; fill_large = 1'b0; fill_va = 32'h0055_A000; fill_pa = 32'h0077_7000;
    lk_valid = 1'b1; lk_va = 32'h0055_A010;
    @(negedge clk);
    fill_en = 1'b0; lk_valid = 1'b0;
    check("R7 same-edge lookup sees old", lk_hit, lk_large, lk_pa, 1'b0, 1'b0, '0);
    look("R7 fill visible next", 32'h0055_A010, 1'b1, 1'b0, 32'h0077_7010);
  endtask

  task automatic t_large_2m();
    do_flush();
    large_mode = 1'b0;
    do_fill(1'b1, 32'h4060_0000, 32'h1FE0_0000);
    look("R4 2M hit", 32'h407F_FFFC, 1'b1, 1'b1, 32'h1FFF_FFFC);
    look("R4 2M next region miss", 32'h4080_0000, 1'b0, 1'b0, '0);
    look("R6 large fill not in small", 32'h4060_0000, 1'b1, 1'b1, 32'h1FE0_0000);
  endtask

  task automatic t_large_4m();
    do_flush();
    large_mode = 1'b0;
    do_fill(1'b1, 32'h0080_0000, 32'h0C00_0000);
    look("R5 bit21 compared in 2M", 32'h00A1_2345, 1'b0, 1'b0, '0);
    look("R4 2M low half", 32'h0081_2345, 1'b1, 1'b1, 32'h0C01_2345);
    do_flush();
    large_mode = 1'b1;
    do_fill(1'b1, 32'h0080_0000, 32'h0C20_0000);
    look("R5 4M upper half", 32'h00A1_2345, 1'b1, 1'b1, 32'h0C21_2345);
    look("R5 4M lower half", 32'h0081_2345, 1'b1, 1'b1, 32'h0C01_2345);
    look("R5 4M next region miss", 32'h00C0_0000, 1'b0, 1'b0, '0);
    do_flush();
    large_mode = 1'b0;
  endtask

  task automatic t_double();
    do_flush();
    do_fill(1'b0, 32'h0040_3000, 32'h1111_1000);
    do_fill(1'b1, 32'h0040_0000, 32'h0800_0000);
    look("R9 double hit large wins", 32'h0040_3123, 1'b1, 1'b1, 32'h0800_3123);
    if (lk_hit) $display("NOTE: overlapping small and large mappings is a software error");
  endtask

  task automatic t_flush();
    do_fill(1'b0, 32'h7000_0000, 32'h0100_0000);
    do_fill(1'b1, 32'h7200_0000, 32'h0200_0000);
    do_flush();
    look("R10 small flushed", 32'h7000_0000, 1'b0, 1'b0, '0);
    look("R10 large flushed", 32'h7200_0000, 1'b0, 1'b0, '0);
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_large = 1'b0;
    fill_va = 32'h7000_0000; fill_pa = 32'h0100_0000;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    look("R10 flush beats fill", 32'h7000_0000, 1'b0, 1'b0, '0);
  endtask

  task automatic t_repl();
    do_flush();
    for (int i = 0; i < 8; i++)
      do_fill(1'b0, 32'h0010_0000 + (i << 12), 32'h0300_0000 + (i << 12));
    look("R8 all eight held", 32'h0010_7004, 1'b1, 1'b0, 32'h0300_7004);
    do_fill(1'b0, 32'h0020_0000, 32'h0400_0000);
    look("R8 entry 0 replaced", 32'h0010_0000, 1'b0, 1'b0, '0);
    look("R8 entry 1 kept", 32'h0010_1008, 1'b1, 1'b0, 32'h0300_1008);
    look("R8 new entry", 32'h0020_0ABC, 1'b1, 1'b0, 32'h0400_0ABC);
    do_fill(1'b0, 32'h0020_1000, 32'h0400_1000);
    look("R8 entry 1 replaced", 32'h0010_1008, 1'b0, 1'b0, '0);
    look("R8 entry 2 kept", 32'h0010_2000, 1'b1, 1'b0, 32'h0300_2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_small();
    t_idle_and_order();
    t_large_2m();
    t_large_4m();
    t_double();
    t_flush();
    t_repl();
    t_repl();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule